// File: doc/BRIEF.md
# Packed Byte Video ALU

This unit performs lane-parallel arithmetic on 32-bit words that each hold four unsigned 8-bit pixels. It targets video and image kernels. It offers five operations. A clipping byte add and a rounding byte average serve blending. An absolute-difference step feeds four running 16-bit sums for motion search. A byte alignment picks four consecutive bytes out of a two-word pair. A clipping halfword add treats the word as two 16-bit lanes.

Each accepted request returns its result one clock later, marked by a valid strobe. The four sum-of-absolute-difference accumulators sit on a separate output bus. They change only when an absolute-difference request is accepted or when a synchronous clear is raised. Instruction decode, the register file and memory access are left to the surrounding core.

Top module: `pbv_alu`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly one clock, and `result` reflects the request accepted on the previous edge.
- R2: Opcode 0 (byte add) gives, for each lane i at bits [8i+7:8i], the value min(src0_i + src1_i, 255).
- R3: Opcode 1 (byte average) gives, for each lane, (src0_i + src1_i + 1) >> 1.
- R4: Opcode 2 (absolute difference) gives |src0_i − src1_i| in each result lane. It also adds that value into accumulator i, held at `acc` bits [16i+15:16i], and the accumulator saturates at 0xFFFF.
- R5: Opcode 3 (alignment) gives bits [8·off+31 : 8·off] of the 64-bit value {src1, src0}, with off = `align_off` (0..3).
- R6: Opcode 4 (halfword add) gives, for each 16-bit half, min(src0_h + src1_h, 65535).
- R7: `acc_clr` zeroes all four accumulators on the next edge, whether or not `in_valid` is high. It overrides an absolute-difference request in the same cycle.
- R8: Accumulators keep their value on idle cycles and on every opcode other than 2.
- R9: Opcodes 5, 6 and 7 are accepted, produce a zero result and assert `out_valid`.
- R10: While `in_valid` is low, `result` holds its last value.
- R11: After reset, `out_valid`, `result` and `acc` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request accepted this cycle |
| op | input | 3 | Operation code |
| src0 | input | 32 | First operand; low word for alignment |
| src1 | input | 32 | Second operand; high word for alignment |
| align_off | input | 2 | Starting byte for alignment |
| acc_clr | input | 1 | Synchronous clear of the accumulators |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Registered result |
| acc | output | 64 | Four 16-bit accumulators, lane 0 in the low bits |

## Verification
The bench drives lanes that sum to exactly 255 and to 256, so a design that wraps or clips one count too early shows a wrong lane. Odd pair sums catch an average that truncates instead of rounding up. It also runs the absolute difference with the smaller operand in either position, which exposes a one-sided subtraction. More than 257 full-scale absolute differences push every accumulator past 0xFFFF, so a wrapping sum would fall back to a small value. The bench sweeps all four alignment offsets, where a swapped word order or a wrong shift unit gives wrong bytes. It raises a clear together with an absolute-difference request, where the wrong priority leaves a non-zero sum.

// File: rtl/pbv_pkg.sv
`timescale 1ns/1ps
package pbv_pkg;
  localparam int OPW = 3;
  localparam logic [OPW-1:0] OP_ADDB  = 3'd0;
  localparam logic [OPW-1:0] OP_AVGB  = 3'd1;
  localparam logic [OPW-1:0] OP_SAD   = 3'd2;
  localparam logic [OPW-1:0] OP_ALIGN = 3'd3;
  localparam logic [OPW-1:0] OP_ADDH  = 3'd4;
endpackage

// File: rtl/pbv_lane.sv
`timescale 1ns/1ps
module pbv_lane #(
  parameter int LW   = 8,
  parameter int ACCW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LW-1:0]   a,
  input  logic [LW-1:0]   b,
  input  logic            do_sad,
  input  logic            acc_clr,
  output logic [LW-1:0]   add_sat,
  output logic [LW-1:0]   avg,
  output logic [LW-1:0]   absd,
  output logic [ACCW-1:0] acc
);
  function automatic logic [LW-1:0] f_sat_add(logic [LW-1:0] x, logic [LW-1:0] y);
    logic [LW:0] s;
    s = {1'b0, x} + {1'b0, y};
    return s[LW] ? {LW{1'b1}} : s[LW-1:0];
  endfunction

  function automatic logic [LW-1:0] f_avg(logic [LW-1:0] x, logic [LW-1:0] y);
    logic [LW:0] s;
    s = {1'b0, x} + {1'b0, y} + {{LW{1'b0}}, 1'b1};
    return s[LW:1];
  endfunction

  function automatic logic [LW-1:0] f_absd(logic [LW-1:0] x, logic [LW-1:0] y);
    return (x >= y) ? (x - y) : (y - x);
  endfunction

  function automatic logic [ACCW-1:0] f_acc(logic [ACCW-1:0] s, logic [LW-1:0] d);
    logic [ACCW:0] t;
    t = {1'b0, s} + {{(ACCW+1-LW){1'b0}}, d};
    return t[ACCW] ? {ACCW{1'b1}} : t[ACCW-1:0];
  endfunction

  logic            acc_at_max;
  logic [ACCW-1:0] acc_next;

  assign add_sat    = f_sat_add(a, b);
  assign avg        = f_avg(a, b);
  assign absd       = f_absd(a, b);
  assign acc_next   = f_acc(acc, absd);
  assign acc_at_max = (acc == {ACCW{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n)       acc <= '0;
    else if (acc_clr) acc <= '0;
    else if (do_sad)  acc <= acc_next;
  end

  // R7: a clear always leaves zero, even with an absolute-difference request
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (acc == '0));
  // R8: no accumulation request and no clear keeps the sum unchanged
  a_r8_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_clr && !do_sad) |=> $stable(acc));
  // R4: accumulation never lowers the sum, and a full sum stays full
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_clr && do_sad) |=> (acc >= $past(acc)));
  a_r4_sticky_max: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_clr && do_sad && acc_at_max) |=> (acc == {ACCW{1'b1}}));
  // R2: the clipped sum is never below either operand
  a_r2_clip_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (add_sat >= a) && (add_sat >= b));
  // R3: the average lies between the two operands
  a_r3_avg_between: assert property (@(posedge clk) disable iff (!rst_n)
    ((a <= b) -> (avg >= a && avg <= b)) && ((a > b) -> (avg >= b && avg <= a)));
endmodule

// File: rtl/pbv_align.sv
`timescale 1ns/1ps
module pbv_align #(
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic [LANES*LW-1:0]       lo,
  input  logic [LANES*LW-1:0]       hi,
  input  logic [$clog2(LANES)-1:0]  off,
  output logic [LANES*LW-1:0]       out
);
  localparam int OFFW = $clog2(LANES);
  localparam int IDXW = OFFW + 1;

  logic [LW-1:0] cat_b [2*LANES];

  for (genvar j = 0; j < LANES; j++) begin : g_split
    assign cat_b[j]         = lo[j*LW +: LW];
    assign cat_b[j + LANES] = hi[j*LW +: LW];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_pick
    logic [IDXW-1:0] idx;
    assign idx = IDXW'(i) + {1'b0, off};
    assign out[i*LW +: LW] = cat_b[idx];
  end
endmodule

// File: rtl/pbv_hadd.sv
`timescale 1ns/1ps
module pbv_hadd #(
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic [LANES*LW-1:0] a,
  input  logic [LANES*LW-1:0] b,
  output logic [LANES*LW-1:0] sum
);
  localparam int HW     = 2 * LW;
  localparam int HLANES = LANES / 2;

  function automatic logic [HW-1:0] f_hsat(logic [HW-1:0] x, logic [HW-1:0] y);
    logic [HW:0] s;
    s = {1'b0, x} + {1'b0, y};
    return s[HW] ? {HW{1'b1}} : s[HW-1:0];
  endfunction

  for (genvar h = 0; h < HLANES; h++) begin : g_half
    assign sum[h*HW +: HW] = f_hsat(a[h*HW +: HW], b[h*HW +: HW]);
  end
endmodule

// File: rtl/pbv_alu.sv
`timescale 1ns/1ps
module pbv_alu #(
  parameter int LANES = 4,
  parameter int LW    = 8,
  parameter int ACCW  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [pbv_pkg::OPW-1:0]     op,
  input  logic [LANES*LW-1:0]         src0,
  input  logic [LANES*LW-1:0]         src1,
  input  logic [$clog2(LANES)-1:0]    align_off,
  input  logic                        acc_clr,
  output logic                        out_valid,
  output logic [LANES*LW-1:0]         result,
  output logic [LANES*ACCW-1:0]       acc
);
  import pbv_pkg::*;

  localparam int W  = LANES * LW;

  logic [W-1:0] add_v, avg_v, abs_v, aln_v, hadd_v, res_next;
  logic         sad_fire;

  assign sad_fire = in_valid && (op == OP_SAD);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pbv_lane #(.LW(LW), .ACCW(ACCW)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .a       (src0[i*LW +: LW]),
      .b       (src1[i*LW +: LW]),
      .do_sad  (sad_fire),
      .acc_clr (acc_clr),
      .add_sat (add_v[i*LW +: LW]),
      .avg     (avg_v[i*LW +: LW]),
      .absd    (abs_v[i*LW +: LW]),
      .acc     (acc[i*ACCW +: ACCW])
    );
  end

  pbv_align #(.LANES(LANES), .LW(LW)) u_align (
    .lo (src0), .hi (src1), .off (align_off), .out (aln_v)
  );

  pbv_hadd #(.LANES(LANES), .LW(LW)) u_hadd (
    .a (src0), .b (src1), .sum (hadd_v)
  );

  always_comb begin
    case (op)
      OP_ADDB:  res_next = add_v;
      OP_AVGB:  res_next = avg_v;
      OP_SAD:   res_next = abs_v;
      OP_ALIGN: res_next = aln_v;
      OP_ADDH:  res_next = hadd_v;
      default:  res_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= res_next;
    end
  end

  // R1: the strobe follows the request by one clock
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R10: no request, no change of result
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  // R9: reserved codes return zero
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op > OP_ADDH) |=> (result == '0));
endmodule

// File: tb/pbv_alu_bench.sv
`timescale 1ns/1ps
module pbv_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic [31:0] src0, src1;
  logic [1:0]  align_off;
  logic        acc_clr;
  logic        out_valid;
  logic [31:0] result;
  logic [63:0] acc;

  always #2.5 clk = ~clk;

  pbv_alu u_pbv_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .src0(src0),
    .src1(src1), .align_off(align_off), .acc_clr(acc_clr),
    .out_valid(out_valid), .result(result), .acc(acc)
  );

  int errs = 0, checks = 0;
  bit done = 0;
  logic        m_v;
  logic [31:0] m_res;
  int          m_acc [4];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [2:0] o, input logic [31:0] a,
                                        input logic [31:0] b, input logic [1:0] off);
    logic [31:0] r = '0;
    logic [63:0] c;
    int x, y, z;
    case (o)
      3'd0, 3'd1, 3'd2:
        for (int i = 0; i < 4; i++) begin
          x = a[8*i +: 8]; y = b[8*i +: 8];
          if (o == 3'd0) z = (x + y > 255) ? 255 : x + y;
          else if (o == 3'd1) z = (x + y + 1) / 2;
          else z = (x > y) ? x - y : y - x;
          r[8*i +: 8] = z[7:0];
        end
      3'd3: begin c = {b, a}; r = c[8*off +: 32]; end
      3'd4:
        for (int h = 0; h < 2; h++) begin
          x = a[16*h +: 16]; y = b[16*h +: 16];
          z = (x + y > 65535) ? 65535 : x + y;
          r[16*h +: 16] = z[15:0];
        end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [63:0] pack_acc();
    logic [63:0] p;
    for (int i = 0; i < 4; i++) p[16*i +: 16] = m_acc[i][15:0];
    return p;
  endfunction

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R9";
    endcase
  endfunction

  // called at a falling edge; drives, models, then checks one falling edge later
  task automatic step(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                      input logic [1:0] off, input logic v, input logic clr);
    int x, y;
    string rq, aq;
    op = o; src0 = a; src1 = b; align_off = off; in_valid = v; acc_clr = clr;
    m_v = v;
    if (v) m_res = model(o, a, b, off);
    if (clr) for (int i = 0; i < 4; i++) m_acc[i] = 0;
    else if (v && o == 3'd2)
      for (int i = 0; i < 4; i++) begin
        x = a[8*i +: 8]; y = b[8*i +: 8];
        m_acc[i] = m_acc[i] + ((x > y) ? x - y : y - x);
        if (m_acc[i] > 65535) m_acc[i] = 65535;
      end
    rq = v ? req_of(o) : "R10";
    aq = clr ? "R7" : ((v && o == 3'd2) ? "R4" : "R8");
    @(posedge clk);
    @(negedge clk);
    chk("R1", {63'd0, out_valid}, {63'd0, m_v});
    chk(rq, {32'd0, result}, {32'd0, m_res});
    chk(aq, acc, pack_acc());
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; op = 0; src0 = 0; src1 = 0; align_off = 0; acc_clr = 0;
    m_v = 0; m_res = 0;
    for (int i = 0; i < 4; i++) m_acc[i] = 0;
    repeat (3) @(negedge clk);
    chk("R11", {63'd0, out_valid}, 64'd0);
    chk("R11", {32'd0, result}, 64'd0);
    chk("R11", acc, 64'd0);
    rst_n = 1;
    @(negedge clk);

    // R2 clip edges: 255 exactly, 256 clipped, zero
    step(3'd0, 32'h80_FF_01_00, 32'h7F_01_FE_00, 2'd0, 1, 0);
    step(3'd0, 32'hFF_FF_C0_10, 32'hFF_00_80_20, 2'd0, 1, 0);
    // R3 odd sums round up
    step(3'd1, 32'h01_FF_00_03, 32'h02_FF_01_04, 2'd0, 1, 0);
    // R4 smaller operand on either side
    step(3'd2, 32'h10_05_FF_00, 32'h05_10_00_FF, 2'd0, 1, 0);
    // R10 idle cycle with changed inputs
    step(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd0, 0, 0);
    // R5 all offsets
    for (int k = 0; k < 4; k++) step(3'd3, 32'h33_22_11_00, 32'h77_66_55_44, k[1:0], 1, 0);
    // R6 halfword clip and no clip
    step(3'd4, 32'hFFFF_1234, 32'h0001_0001, 2'd0, 1, 0);
    step(3'd4, 32'h8000_7FFF, 32'h7FFF_8000, 2'd0, 1, 0);
    // R9 reserved codes
    for (int k = 5; k < 8; k++) step(k[2:0], 32'h1234_5678, 32'h9ABC_DEF0, 2'd1, 1, 0);
    // R7 clear alongside an accumulation
    step(3'd2, 32'hFF_FF_FF_FF, 32'h0, 2'd0, 1, 1);
    // R4 saturation: 300 full-scale differences
    for (int k = 0; k < 300; k++)
      step(3'd2, (k % 2 == 0) ? 32'hFF_FF_FF_FF : 32'h0,
                 (k % 2 == 0) ? 32'h0 : 32'hFF_FF_FF_FF, 2'd0, 1, 0);
    // R8 other ops leave the full sums alone
    step(3'd0, 32'h01010101, 32'h01010101, 2'd0, 1, 0);
    // R7 clear without a request
    step(3'd0, 32'h0, 32'h0, 2'd0, 0, 1);
    // mixed traffic
    for (int k = 0; k < 3000; k++)
      step(3'($urandom_range(0, 7)), $urandom, $urandom, 2'($urandom_range(0, 3)),
           $urandom_range(0, 3) != 0, $urandom_range(0, 31) == 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule